// File: doc/BRIEF.md
# Serial Video Receiver Back End: Descrambler, Word Aligner and Timing-Reference Tracker

This block sits behind the clock-recovery stage of a serial digital video receiver. It takes one recovered bit per bit-clock cycle and, depending on a single mode pin, either undoes the line coding or passes the raw bits through. The line coding is a transition code with polynomial x + 1 and a self-synchronizing scrambler with polynomial x^9 + x^4 + 1. The resulting bit stream is searched, at every bit position, for the 30-bit timing-reference preamble. The word boundary is pinned to the first match, and the stream is then delivered as 10-bit parallel words with a companion word clock whose rising edge sits in the middle of each word.

The word that follows each preamble is the identifier. Its bit 9 qualifies it, and its bit 4 tells the start of active video from the end. The identifier drives a horizontal flag: low once a start code is seen, high once an end code is seen. A lock output rises after a long, parameterized number of words at a stable word boundary. It drops when the preamble turns up at a new bit offset, and also when no preamble has been seen for another parameterized number of words. In pass-through mode the horizontal flag has no defined meaning and downstream logic must not use it.

Top module: `sdi_rx_backend`

## Requirements
- R1: With `bypass` = 0, each input bit n is decoded as d = s(n) ^ s(n-4) ^ s(n-9), where s(n) = in(n) ^ in(n-1); the decoder history is zero after reset. Words are assembled least significant bit first.
- R2: With `bypass` = 1, the input bits are used as received, with no transition decoding and no descrambling, and are assembled into words in the same bit order.
- R3: The 30-bit pattern made of the word 0x3FF followed by 0x000 and 0x000 (each word sent LSB first) is found at any bit offset. The third preamble word (0x000) is presented on `word_out` as a word, and every later word lies on that boundary.
- R4: `word_out` changes only at a word boundary, where `word_clk` falls. `word_clk` rises 5 bit-clock cycles after the boundary and falls again 5 cycles later, so that each word is held for 10 cycles.
- R5: The identifier is the word right after a preamble. When its bit 9 is 1, `hflag` takes the value of its bit 4: 0 (start of active video) drives it low and 1 (end of active video) drives it high. The new value is visible by the next `word_clk` rising edge.
- R6: An identifier whose bit 9 is 0 leaves `hflag` unchanged.
- R8: `locked` rises on the LOCK_WORDS-th word after the preamble that established the word boundary. Every later word counts, including further preamble words at the same offset.
- R9: A preamble found at a bit offset different from the current boundary clears `locked` and restarts the lock count from that preamble. A preamble at the same offset leaves `locked` set.
- R10: The MISS_WORDS-th consecutive word without a completed preamble clears `locked`. The next preamble re-establishes the boundary, and `locked` rises again LOCK_WORDS words after it.
- R11: While `rst_n` is low, the outputs are `word_out` = 0, `word_clk` = 0, `hflag` = 1 and `locked` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Recovered serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | 0: transition decode and descramble; 1: raw bits straight to alignment |
| ser_in | input | 1 | Serial data, one bit per bit-clock cycle |
| word_out | output | 10 | Aligned parallel word |
| word_clk | output | 1 | Word-rate clock, rising mid-word |
| hflag | output | 1 | Horizontal flag from the identifier words (undefined in bypass) |
| locked | output | 1 | Word boundary stable for the settling period |

## Verification
The bench builds the block with LOCK_WORDS = 8 and MISS_WORDS = 24 in place of the defaults of about a thousand and two thousand words. With these values the lock rise, the clearing on a shifted preamble, and the clearing and recovery after a preamble drought all happen within a few hundred words. They can therefore be checked at the exact word where each should occur. The 10-bit word and the tap positions 4 and 9 stay at their real values, so the descrambler is exercised against an independent scrambler and transition encoder in the bench.

// File: rtl/sdi_rx_pkg.sv
// Shared constants for the serial video receiver back end.
// Assumes 10-bit words sent least significant bit first.
package sdi_rx_pkg;
    localparam int WORD_W       = 10;
    localparam int WORD_HALF    = WORD_W / 2;
    localparam int PRE_W        = 3 * WORD_W;
    // Preamble 0x3FF, 0x000, 0x000 as it sits in a right-shifting window
    localparam logic [PRE_W-1:0] PRE_PATTERN = {{(2*WORD_W){1'b0}}, {WORD_W{1'b1}}};
    localparam int ID_VALID_BIT = 9;
    localparam int ID_EAV_BIT   = 4;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sdi_bit_decoder.sv
// Transition (x+1) decoder followed by a self-synchronizing descrambler
// (x^TAP_B + x^TAP_A + 1). Output is combinational from the current input
// bit so the aligner sees each bit in the cycle it arrives.
// Assumes history starts at zero after reset; in bypass the raw bit is used.
module sdi_bit_decoder #(
    parameter int TAP_A = 4,
    parameter int TAP_B = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic ser_in,
    output logic dec_bit
);
    logic             prev_raw;
    logic [TAP_B-1:0] hist;      // hist[0] is the newest transition-decoded bit
    logic             trans_bit;
    logic             descr_bit;

    // Decode transition coding, then remove the scrambling taps.
    always_comb begin
        trans_bit = ser_in ^ prev_raw;
        descr_bit = trans_bit ^ hist[TAP_A-1] ^ hist[TAP_B-1];
        dec_bit   = bypass ? ser_in : descr_bit;
    end

    // Advance both shift registers by one bit per bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_raw <= 1'b0;
            hist     <= '0;
        end else begin
            prev_raw <= ser_in;
            hist     <= {hist[TAP_B-2:0], trans_bit};
        end
    end
endmodule

// File: rtl/sdi_word_aligner.sv
// Searches the bit stream at every offset for the 30-bit preamble, pins the
// word boundary to it and emits 10-bit words with a mid-word word clock.
// Outputs word_stb/pre_hit/realign are one-cycle pulses aligned with a new word_q.
module sdi_word_aligner
    import sdi_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_in,
    output word_t word_q,
    output logic  word_clk,
    output logic  word_stb,
    output logic  pre_hit,
    output logic  realign
);
    localparam int CW = $clog2(WORD_W);

    logic [PRE_W-1:0] win_q;
    logic [PRE_W-1:0] win_next;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    cnt_next;
    logic             hit;
    logic             last_bit;
    logic             boundary;

    // Slide the window and decide whether this bit closes a word.
    always_comb begin
        win_next = {bit_in, win_q[PRE_W-1:1]};
        hit      = (win_next == PRE_PATTERN);
        last_bit = (cnt_q == CW'(WORD_W - 1));
        boundary = last_bit | hit;
        cnt_next = boundary ? '0 : cnt_q + 1'b1;
    end

    // Register the window, bit phase, word and word clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            cnt_q    <= '0;
            word_q   <= '0;
            word_clk <= 1'b0;
        end else begin
            win_q    <= win_next;
            cnt_q    <= cnt_next;
            word_clk <= (cnt_next >= CW'(WORD_HALF));
            if (boundary) word_q <= win_next[PRE_W-1 -: WORD_W];
        end
    end

    // Flag word completions, preambles and boundary moves for the tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_stb <= 1'b0;
            pre_hit  <= 1'b0;
            realign  <= 1'b0;
        end else begin
            word_stb <= boundary;
            pre_hit  <= hit;
            realign  <= hit & ~last_bit;
        end
    end
endmodule

// File: rtl/sdi_trs_tracker.sv
// Decodes identifier words into the horizontal flag and runs the lock and
// preamble-drought counters, advancing once per word strobe.
// Assumes word_stb marks each new word and pre_hit/realign come with it.
module sdi_trs_tracker
    import sdi_rx_pkg::*;
#(
    parameter int LOCK_WORDS = 1026,
    parameter int MISS_WORDS = 2200
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  word_stb,
    input  logic  pre_hit,
    input  logic  realign,
    input  word_t word,
    output logic  hflag,
    output logic  locked
);
    localparam int LCW = $clog2(LOCK_WORDS + 1);
    localparam int MCW = $clog2(MISS_WORDS + 1);

    logic           id_pending;
    logic           aligned;
    logic [LCW-1:0] lock_cnt;
    logic [MCW-1:0] miss_cnt;
    logic           lock_full;
    logic           miss_full;

    // Terminal counts of the two word counters.
    always_comb begin
        lock_full = (lock_cnt == LCW'(LOCK_WORDS - 1));
        miss_full = (miss_cnt == MCW'(MISS_WORDS - 1));
    end

    // Latch the start/end flag from a qualified identifier word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_pending <= 1'b0;
            hflag      <= 1'b1;
        end else if (word_stb) begin
            id_pending <= pre_hit;
            if (id_pending && word[ID_VALID_BIT]) hflag <= word[ID_EAV_BIT];
        end
    end

    // Settling timer, drought timer and lock output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned  <= 1'b0;
            lock_cnt <= '0;
            miss_cnt <= '0;
            locked   <= 1'b0;
        end else if (word_stb) begin
            if (pre_hit) begin
                aligned  <= 1'b1;
                miss_cnt <= '0;
                if (realign || !aligned) begin
                    lock_cnt <= '0;
                    locked   <= 1'b0;
                end else if (lock_full) begin
                    locked   <= 1'b1;
                end else begin
                    lock_cnt <= lock_cnt + 1'b1;
                end
            end else if (aligned) begin
                if (miss_full) begin
                    aligned  <= 1'b0;
                    miss_cnt <= '0;
                    lock_cnt <= '0;
                    locked   <= 1'b0;
                end else begin
                    miss_cnt <= miss_cnt + 1'b1;
                    if (lock_full) locked   <= 1'b1;
                    else           lock_cnt <= lock_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sdi_rx_backend.sv
// Top of the receiver back end: bit decoder, word aligner, TRS tracker.
// Assumes one serial bit per bit_clk cycle; bypass is static between resets.
module sdi_rx_backend
    import sdi_rx_pkg::*;
#(
    parameter int LOCK_WORDS = 1026,
    parameter int MISS_WORDS = 2200
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              ser_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_clk,
    output logic              hflag,
    output logic              locked
);
    logic dec_w;
    logic stb_w;
    logic pre_w;
    logic realign_w;

    sdi_bit_decoder #(.TAP_A(4), .TAP_B(9)) u_dec (
        .clk(bit_clk), .rst_n(rst_n), .bypass(bypass),
        .ser_in(ser_in), .dec_bit(dec_w)
    );

    sdi_word_aligner u_align (
        .clk(bit_clk), .rst_n(rst_n), .bit_in(dec_w),
        .word_q(word_out), .word_clk(word_clk), .word_stb(stb_w),
        .pre_hit(pre_w), .realign(realign_w)
    );

    sdi_trs_tracker #(.LOCK_WORDS(LOCK_WORDS), .MISS_WORDS(MISS_WORDS)) u_trs (
        .clk(bit_clk), .rst_n(rst_n), .word_stb(stb_w), .pre_hit(pre_w),
        .realign(realign_w), .word(word_out), .hflag(hflag), .locked(locked)
    );
endmodule

// File: rtl/sdi_rx_backend_chk.sv
// Temporal checks on the receiver back end, attached by bind.
module sdi_rx_backend_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       word_clk,
    input logic [9:0] word_out,
    input logic       hflag,
    input logic       locked,
    input logic       word_stb,
    input logic       realign
);
    // R4: the word is steady when the word clock rises
    a_r4_rise_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_clk) |-> $stable(word_out));

    // R4: the word only changes while the word clock is low
    a_r4_change_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> !word_clk);

    // R5: the horizontal flag moves only right after a word strobe
    a_r5_hflag_on_word: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hflag) |-> $past(word_stb));

    // R8: lock rises only right after a word strobe
    a_r8_lock_on_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(word_stb));

    // R9: a boundary move leaves lock low in the following cycle
    a_r9_realign_drops: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> !locked);
endmodule

bind sdi_rx_backend sdi_rx_backend_chk u_chk (
    .clk(bit_clk), .rst_n(rst_n), .word_clk(word_clk), .word_out(word_out),
    .hflag(hflag), .locked(locked), .word_stb(stb_w), .realign(realign_w)
);

// File: tb/sdi_rx_backend_test.sv
// Scoreboard bench: the driver encodes words serially and queues the
// expected word/flag/lock; the monitor pops one entry per word-clock rise.
module sdi_rx_backend_test;
    localparam int LOCKW = 8;
    localparam int MISSW = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bypass = 1'b0;
    logic       ser_in = 1'b0;
    logic [9:0] word_out;
    logic       word_clk;
    logic       hflag;
    logic       locked;

    sdi_rx_backend #(.LOCK_WORDS(LOCKW), .MISS_WORDS(MISSW)) uut (
        .bit_clk(clk), .rst_n(rst_n), .bypass(bypass), .ser_in(ser_in),
        .word_out(word_out), .word_clk(word_clk), .hflag(hflag), .locked(locked)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [9:0] w;
        logic       h;
        bit         hc;
        logic       lk;
        int         wt;
        int         ht;
        int         lt;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   track = 0;
    bit   skip_r4 = 0;
    bit   done = 0;

    // encoder state
    logic [8:0] enc = '0;
    logic       nprev = 1'b0;
    // expectation model
    bit   b_al = 0;
    int   since_est = 0;
    int   since_pre = 0;
    bit   last_pre = 0;
    logic exp_h = 1'b1;
    int   cur_wt = 1;
    int   cur_ht = 5;
    int   cur_lt = 8;

    function automatic string tg(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            8: return "R8";   9: return "R9";   10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input int t, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tg(t), what, act, expv);
        end
    endtask

    task automatic send_bit(input logic b);
        logic scr;
        logic o;
        if (bypass) o = b;
        else begin
            scr   = b ^ enc[3] ^ enc[8];
            enc   = {enc[7:0], scr};
            o     = scr ^ nprev;
            nprev = o;
        end
        ser_in = o;
        @(posedge clk);
        #1;
    endtask

    task automatic model_word(input logic [9:0] w, input bit is_pre, input bit re);
        if (last_pre && w[9]) exp_h = w[4];
        last_pre = is_pre;
        if (is_pre) begin
            if (!b_al || re) since_est = 0;
            else since_est++;
            b_al = 1;
            since_pre = 0;
        end else if (b_al) begin
            since_pre++;
            if (since_pre == MISSW) begin
                b_al = 0;
                since_est = 0;
            end else since_est++;
        end
    endtask

    task automatic push_exp(input logic [9:0] w, input int wt);
        exp_t e;
        e.w = w; e.h = exp_h; e.hc = !bypass; e.lk = b_al && (since_est >= LOCKW);
        e.wt = wt; e.ht = cur_ht; e.lt = cur_lt;
        sbq.push_back(e);
    endtask

    task automatic send_bits(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    task automatic send_word(input logic [9:0] w, input bit is_pre, input bit push);
        model_word(w, is_pre, 0);
        if (push && track) push_exp(w, is_pre ? 3 : cur_wt);
        send_bits(w);
    endtask

    function automatic logic [9:0] data_w(input int k);
        return 10'h102 | 10'((k * 53) & 10'h2FD);
    endfunction

    task automatic send_data(input int n, input int base);
        for (int k = 0; k < n; k++) send_word(data_w(base + k), 0, 1);
    endtask

    // Preamble at the current boundary, then identifier.
    task automatic send_trs(input logic [9:0] id);
        send_word(10'h3FF, 0, 1);
        send_word(10'h000, 0, 1);
        send_word(10'h000, 1, 1);
        send_word(id, 0, 1);
    endtask

    // Preamble that (re)establishes the boundary; tracking starts after it.
    task automatic send_est(input logic [9:0] id, input bit re);
        track = 0;
        sbq.delete();
        send_word(10'h3FF, 0, 0);
        send_word(10'h000, 0, 0);
        model_word(10'h000, 1, re);
        send_bits(10'h000);
        push_exp(10'h000, 3);
        skip_r4 = 1;
        track = 1;
        send_word(id, 0, 1);
    endtask

    task automatic do_reset(input logic mode);
        track = 0;
        sbq.delete();
        rst_n = 1'b0;
        bypass = mode;
        ser_in = 1'b0;
        enc = '0; nprev = 1'b0;
        b_al = 0; since_est = 0; since_pre = 0; last_pre = 0; exp_h = 1'b1;
        repeat (4) @(posedge clk);
        #4;
        check(11, "word_out in reset", word_out, 0);
        check(11, "word_clk in reset", word_clk, 0);
        check(11, "hflag in reset", hflag, 1);
        check(11, "locked in reset", locked, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic drain();
        repeat (12) send_bit(1'b0);
        track = 0;
        check(4, "scoreboard left over", sbq.size(), 0);
        sbq.delete();
    endtask

    // Monitor: word-clock timing and scoreboard compare on each rise.
    logic prev_wc = 1'b0;
    int   since_fall = 0;
    int   since_rise = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_wc = 1'b0;
            since_fall = 0;
            since_rise = 0;
        end else begin
            since_fall++;
            since_rise++;
            if (word_clk && !prev_wc) begin
                if (track && !skip_r4) check(4, "cycles fall to rise", since_fall, 5);
                skip_r4 = 0;
                if (track) begin
                    if (sbq.size() == 0) check(3, "unexpected word", word_out, 0);
                    else begin
                        exp_t e;
                        e = sbq.pop_front();
                        check(e.wt, "word_out", word_out, e.w);
                        check(e.lt, "locked", locked, e.lk);
                        if (e.hc) check(e.ht, "hflag", hflag, e.h);
                    end
                end
                since_rise = 0;
            end else if (!word_clk && prev_wc) begin
                if (track && !skip_r4) check(4, "cycles rise to fall", since_rise, 5);
                since_fall = 0;
            end
            prev_wc = word_clk;
        end
    end

    initial begin
        // R1, R3, R5, R6, R8: descrambled stream
        do_reset(1'b0);
        cur_wt = 1; cur_lt = 8; cur_ht = 5;
        send_data(4, 0);
        send_est(10'h200, 0);
        send_data(12, 10);
        send_trs(10'h274);
        send_data(6, 30);
        send_trs(10'h200);
        send_data(6, 40);
        cur_ht = 6;
        send_trs(10'h074);
        send_data(4, 50);
        // R9: boundary shifted by three bits
        cur_ht = 5; cur_lt = 9;
        track = 0;
        sbq.delete();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_est(10'h274, 1);
        send_data(10, 60);
        // R10: preamble drought, then recovery
        cur_lt = 10;
        send_data(30, 80);
        send_trs(10'h200);
        send_data(10, 120);
        drain();
        // R2: raw bits, hflag unchecked
        do_reset(1'b1);
        cur_wt = 2; cur_lt = 8;
        send_data(3, 140);
        send_est(10'h200, 0);
        send_data(10, 150);
        send_trs(10'h274);
        send_data(4, 170);
        drain();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule